// File: doc/BRIEF.md
# Interrupt Line Register Bank

This block keeps the per-line state that an interrupt controller needs: an enable flag, a pending flag, an active flag and a four-bit priority for each of `NUM_LINES` request lines. The default is 82 lines. Software reaches that state through a 32-bit word-addressed register port. Enable and pending are each changed through a pair of windows: one sets bits where a 1 is written, the other clears them. A 0 bit leaves the state alone. Either window of a pair reads back the same current state.

Hardware also moves the state. A rising edge on a request input marks its line pending, whether or not the line is enabled. The arbiter outside the block picks a winner from the exported enable, pending and priority vectors. When it acknowledges a line, that line's pending flag drops and its active flag rises on the same clock edge. A completion strobe later clears the active flag. A software trigger word can make any implemented line pending by writing the line's number.

The block is plain registered logic with no sequencing of its own, so it has no state machine. Each line is an independent cell. In each cell, a set and a clear that arrive on the same edge resolve in favour of the set.

Top module: `irq_line_bank`

## Requirements
- R1: After reset, every enable, pending and active flag is 0, every priority is 0, and `bus_rdata` is 0.
- R2: A write at byte offset 0x000 + 4k sets enable for each line 32k+n where data bit n is 1. A write at 0x080 + 4k clears those enables. Data bits that are 0 change nothing. A read of either offset returns the enable flags of that word.
- R3: Offsets 0x100 + 4k (set) and 0x180 + 4k (clear) act on the pending flags in the same way, and both offsets read back the pending flags.
- R4: Word k bit n always refers to line 32k+n. Bits for lines at or above `NUM_LINES` read 0 and writes to them are dropped. With the default of 82 lines, word 2 holds only bits 17:0, and words 3 and up read 0.
- R5: A 0-to-1 transition on `irq_req[i]` sets pending for line i one edge later, whatever the line's enable. A request held high does not set the flag again after software has cleared it.
- R6: `ack_stb` with line number `ack_id` clears that line's pending flag and sets its active flag on the same edge.
- R7: The active flags read at offset 0x200 + 4k. Writes there change nothing. `done_stb` with `done_id` clears that line's active flag.
- R8: Priority word j at 0x300 + 4j holds lines 4j to 4j+3, one byte each, with the lowest line in bits 7:0. Only the upper four bits of each byte are stored. The lower four bits read 0. `line_prio[4i+3:4i]` carries line i's stored value.
- R9: Writing a value v to offset 0xE00 sets pending for line v, where v is taken from data bits 7:0. Values of `NUM_LINES` or more do nothing.
- R10: Offsets outside the windows read 0 and ignore writes. This covers offsets with address bits 1:0 not zero, priority offsets 0x3F0 and up, and offset 0x400. No flag or priority changes when such an offset is written.
- R11: When a set and a clear of the same pending or active flag land on the same edge, the flag ends up set. One example is a request edge together with an acknowledge. Another is a request edge together with a clear-pending write.
- R12: `bus_rdata` is loaded on the edge where `bus_rd` is high, from the state before that edge. It holds its value on every edge where `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data appears after the edge |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | input | NUM_LINES | Request level per line; rising edges are captured |
| ack_stb | input | 1 | Arbiter acknowledge strobe |
| ack_id | input | ID_W | Line number being acknowledged |
| done_stb | input | 1 | Handler completion strobe |
| done_id | input | ID_W | Line number that completed |
| line_en | output | NUM_LINES | Enable flags to the arbiter |
| line_pend | output | NUM_LINES | Pending flags to the arbiter |
| line_prio | output | 4*NUM_LINES | Stored four-bit priority per line |

## Verification
The bench builds the block with its defaults: 82 lines and 8-bit line numbers. With these values the third word of each bit window is partly implemented and the fourth is not there at all. That lets the bench test the boundary between line 81 and line 82 at the register port, in the priority word that holds lines 80 to 83, and in the software trigger. The same settings also bring the same-edge conflicts on one line within reach: a request edge with an acknowledge, and a request edge with a clear-pending write.

// File: rtl/irq_line_bank_pkg.sv
package irq_line_bank_pkg;

    // Register window selected by a bus offset
    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_EN_SET,
        WIN_EN_CLR,
        WIN_PD_SET,
        WIN_PD_CLR,
        WIN_ACTIVE,
        WIN_PRIO,
        WIN_TRIG
    } win_e;

    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;
    localparam int PRIO_W      = 4;
    localparam int BYTE_W      = 8;
    localparam int LINES_PER_W = DATA_W / BYTE_W;
    localparam int PRIO_WORDS  = 60;   // 240 priority bytes
    localparam int BIT_WORDS   = 8;    // 256 lines per bit window

endpackage

// File: rtl/irq_line_bank_decode.sv
module irq_line_bank_decode
    import irq_line_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [4:0]        word_idx,
    output logic [5:0]        prio_idx
);

    always_comb begin
        win      = WIN_NONE;
        word_idx = addr[6:2];
        prio_idx = addr[7:2];
        if (addr[1:0] == 2'b00) begin
            unique case (addr[11:7])
                5'd0:    win = WIN_EN_SET;
                5'd1:    win = WIN_EN_CLR;
                5'd2:    win = WIN_PD_SET;
                5'd3:    win = WIN_PD_CLR;
                5'd4:    win = WIN_ACTIVE;
                5'd6,
                5'd7:    win = (addr[7:2] < 6'(PRIO_WORDS)) ? WIN_PRIO : WIN_NONE;
                5'h1C:   win = (addr[6:2] == 5'd0) ? WIN_TRIG : WIN_NONE;
                default: win = WIN_NONE;
            endcase
        end
    end

endmodule

// File: rtl/irq_line_bank_cell.sv
module irq_line_bank_cell
    import irq_line_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              pd_set,
    input  logic              pd_clr,
    input  logic              act_set,
    input  logic              act_clr,
    input  logic              prio_we,
    input  logic [PRIO_W-1:0] prio_d,
    output logic              en_q,
    output logic              pd_q,
    output logic              act_q,
    output logic [PRIO_W-1:0] prio_q
);

    // Set has precedence over clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pd_q   <= 1'b0;
            act_q  <= 1'b0;
            prio_q <= '0;
        end else begin
            if (en_set)       en_q <= 1'b1;
            else if (en_clr)  en_q <= 1'b0;
            if (pd_set)       pd_q <= 1'b1;
            else if (pd_clr)  pd_q <= 1'b0;
            if (act_set)      act_q <= 1'b1;
            else if (act_clr) act_q <= 1'b0;
            if (prio_we)      prio_q <= prio_d;
        end
    end

    // R11
    pend_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_set |=> pd_q);

    // R3
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_clr && !pd_set) |=> !pd_q);

    // R6
    ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_set |=> act_q);

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_set && !act_clr) |=> $stable(act_q));

    // R8
    prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_we |=> $stable(prio_q));

endmodule

// File: rtl/irq_line_bank_rdmux.sv
module irq_line_bank_rdmux
    import irq_line_bank_pkg::*;
#(
    parameter int NUM_LINES = 82
) (
    input  win_e                         win,
    input  logic [4:0]                   word_idx,
    input  logic [5:0]                   prio_idx,
    input  logic [NUM_LINES-1:0]         en_vec,
    input  logic [NUM_LINES-1:0]         pd_vec,
    input  logic [NUM_LINES-1:0]         act_vec,
    input  logic [NUM_LINES*PRIO_W-1:0]  prio_vec,
    output logic [DATA_W-1:0]            rd_word
);

    localparam int NW      = (NUM_LINES + DATA_W - 1) / DATA_W;
    localparam int NPW     = (NUM_LINES + LINES_PER_W - 1) / LINES_PER_W;
    localparam int SEG_W   = LINES_PER_W * PRIO_W;

    logic [NW*DATA_W-1:0]  en_pad, pd_pad, act_pad;
    logic [NPW*SEG_W-1:0]  prio_pad;
    logic [SEG_W-1:0]      prio_seg;

    assign en_pad   = (NW*DATA_W)'(en_vec);
    assign pd_pad   = (NW*DATA_W)'(pd_vec);
    assign act_pad  = (NW*DATA_W)'(act_vec);
    assign prio_pad = (NPW*SEG_W)'(prio_vec);

    always_comb begin
        prio_seg = '0;
        if (int'(prio_idx) < NPW) prio_seg = prio_pad[int'(prio_idx)*SEG_W +: SEG_W];
    end

    always_comb begin
        rd_word = '0;
        unique case (win)
            WIN_EN_SET, WIN_EN_CLR:
                if (int'(word_idx) < NW) rd_word = en_pad[int'(word_idx)*DATA_W +: DATA_W];
            WIN_PD_SET, WIN_PD_CLR:
                if (int'(word_idx) < NW) rd_word = pd_pad[int'(word_idx)*DATA_W +: DATA_W];
            WIN_ACTIVE:
                if (int'(word_idx) < NW) rd_word = act_pad[int'(word_idx)*DATA_W +: DATA_W];
            WIN_PRIO:
                for (int b = 0; b < LINES_PER_W; b++)
                    rd_word[b*BYTE_W + (BYTE_W-PRIO_W) +: PRIO_W] = prio_seg[b*PRIO_W +: PRIO_W];
            default: rd_word = '0;
        endcase
    end

endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank
    import irq_line_bank_pkg::*;
#(
    parameter int NUM_LINES = 82,
    parameter int ID_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [11:0]                   bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic [NUM_LINES-1:0]          irq_req,
    input  logic                          ack_stb,
    input  logic [ID_W-1:0]               ack_id,
    input  logic                          done_stb,
    input  logic [ID_W-1:0]               done_id,
    output logic [NUM_LINES-1:0]          line_en,
    output logic [NUM_LINES-1:0]          line_pend,
    output logic [NUM_LINES*4-1:0]        line_prio
);

    win_e                    win;
    logic [4:0]              word_idx;
    logic [5:0]              prio_idx;
    logic [NUM_LINES-1:0]    req_prev;
    logic [NUM_LINES-1:0]    req_rise;
    logic [NUM_LINES-1:0]    act_vec;
    logic [DATA_W-1:0]       rd_word;
    logic                    trig_hit;
    logic [ID_W-1:0]         trig_id;

    irq_line_bank_decode u_dec (
        .addr     (bus_addr),
        .win      (win),
        .word_idx (word_idx),
        .prio_idx (prio_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_prev <= '0;
        else        req_prev <= irq_req;
    end
    assign req_rise = irq_req & ~req_prev;

    assign trig_hit = bus_wr && (win == WIN_TRIG);
    assign trig_id  = bus_wdata[ID_W-1:0];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int WI = i / DATA_W;
        localparam int BI = i % DATA_W;
        localparam int PW = i / LINES_PER_W;
        localparam int PB = i % LINES_PER_W;

        logic word_hit, prio_hit;
        assign word_hit = bus_wr && (word_idx == 5'(WI));
        assign prio_hit = bus_wr && (win == WIN_PRIO) && (prio_idx == 6'(PW));

        irq_line_bank_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_set  (word_hit && win == WIN_EN_SET && bus_wdata[BI]),
            .en_clr  (word_hit && win == WIN_EN_CLR && bus_wdata[BI]),
            .pd_set  (req_rise[i] ||
                      (word_hit && win == WIN_PD_SET && bus_wdata[BI]) ||
                      (trig_hit && trig_id == ID_W'(i))),
            .pd_clr  ((word_hit && win == WIN_PD_CLR && bus_wdata[BI]) ||
                      (ack_stb && ack_id == ID_W'(i))),
            .act_set (ack_stb && ack_id == ID_W'(i)),
            .act_clr (done_stb && done_id == ID_W'(i)),
            .prio_we (prio_hit),
            .prio_d  (bus_wdata[PB*BYTE_W + (BYTE_W-PRIO_W) +: PRIO_W]),
            .en_q    (line_en[i]),
            .pd_q    (line_pend[i]),
            .act_q   (act_vec[i]),
            .prio_q  (line_prio[i*PRIO_W +: PRIO_W])
        );
    end

    irq_line_bank_rdmux #(.NUM_LINES(NUM_LINES)) u_rd (
        .win      (win),
        .word_idx (word_idx),
        .prio_idx (prio_idx),
        .en_vec   (line_en),
        .pd_vec   (line_pend),
        .act_vec  (act_vec),
        .prio_vec (line_prio),
        .rd_word  (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R2
    enable_only_by_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(line_en));

    // R8
    prio_only_by_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(line_prio));

endmodule

// File: tb/sim_irq_line_bank.sv
`timescale 1ns/1ps
module sim_irq_line_bank;

    localparam int N  = 82;
    localparam int IW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    irq_req = '0;
    logic            ack_stb = 1'b0, done_stb = 1'b0;
    logic [IW-1:0]   ack_id = '0, done_id = '0;
    logic [N-1:0]    line_en, line_pend;
    logic [N*4-1:0]  line_prio;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_line_bank #(.NUM_LINES(N), .ID_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .ack_stb(ack_stb), .ack_id(ack_id),
        .done_stb(done_stb), .done_id(done_id),
        .line_en(line_en), .line_pend(line_pend), .line_prio(line_prio)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ack(input int id);
        @(negedge clk);
        ack_stb = 1'b1; ack_id = IW'(id);
        @(negedge clk);
        ack_stb = 1'b0;
    endtask

    task automatic done(input int id);
        @(negedge clk);
        done_stb = 1'b1; done_id = IW'(id);
        @(negedge clk);
        done_stb = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 enable", line_en, '0);
        chk("R1 pending", line_pend, '0);
        chk("R1 prio", line_prio[127:0], '0);
        chk("R1 rdata", bus_rdata, '0);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        wr(12'h000, 32'h0000_0005);
        chk("R2 set", line_en, 128'h5);
        wr(12'h000, 32'h0);
        chk("R2 zero write", line_en, 128'h5);
        wr(12'h080, 32'h1);
        chk("R2 clear", line_en, 128'h4);
        rd(12'h000, d); chk("R2 read set window", d, 32'h4);
        rd(12'h080, d); chk("R2 read clear window", d, 32'h4);
        wr(12'h004, 32'h8000_0001);
        chk("R4 word1 mapping", line_en, (128'h1 << 63) | (128'h1 << 32) | 128'h4);
        wr(12'h084, 32'hFFFF_FFFF);
        wr(12'h080, 32'h4);
    endtask

    task automatic t_bounds;
        logic [31:0] d;
        wr(12'h008, 32'hFFFF_FFFF);
        chk("R4 word2 lines", line_en, ((128'h1 << 18) - 1) << 64);
        rd(12'h008, d); chk("R4 word2 read", d, 32'h0003_FFFF);
        wr(12'h00C, 32'hFFFF_FFFF);
        rd(12'h00C, d); chk("R4 word3 read", d, 32'h0);
        wr(12'h088, 32'hFFFF_FFFF);
        chk("R4 clear word2", line_en, '0);
    endtask

    task automatic t_pending;
        logic [31:0] d;
        wr(12'h104, 32'h0000_0300);
        chk("R3 set", line_pend, 128'h3 << 40);
        rd(12'h184, d); chk("R3 read clear window", d, 32'h300);
        wr(12'h184, 32'h0000_0100);
        chk("R3 clear", line_pend, 128'h1 << 41);
        wr(12'h184, 32'hFFFF_FFFF);
        chk("R3 clear all", line_pend, '0);
    endtask

    task automatic t_request;
        @(negedge clk); irq_req[10] = 1'b1;
        @(negedge clk);
        chk("R5 rise sets pending while disabled", line_pend, 128'h1 << 10);
        wr(12'h180, 32'h400);
        repeat (2) @(negedge clk);
        chk("R5 held level no re-set", line_pend, '0);
        irq_req[10] = 1'b0;
        @(negedge clk); irq_req[10] = 1'b1;
        @(negedge clk);
        chk("R5 second rise", line_pend, 128'h1 << 10);
    endtask

    task automatic t_ack;
        logic [31:0] d;
        ack(10);
        chk("R6 ack clears pending", line_pend, '0);
        rd(12'h200, d); chk("R6 active set", d, 32'h400);
        wr(12'h200, 32'h0);
        wr(12'h200, 32'hFFFF_FFFF);
        rd(12'h200, d); chk("R7 active write ignored", d, 32'h400);
        done(10);
        rd(12'h200, d); chk("R7 done clears active", d, 32'h0);
        irq_req[10] = 1'b0;
    endtask

    task automatic t_prio;
        logic [31:0] d;
        wr(12'h300, 32'hF1A2_B3C4);
        chk("R8 line prio out", line_prio[15:0], 16'hFABC);
        rd(12'h300, d); chk("R8 low nibbles zero", d, 32'hF0A0_B0C0);
        wr(12'h350, 32'hFFFF_FFFF);
        rd(12'h350, d); chk("R8 word of line 81", d, 32'h0000_F0F0);
        chk("R8 line 81 prio", line_prio[N*4-1 -: 8], 8'hFF);
    endtask

    task automatic t_trig;
        wr(12'hE00, 32'd81);
        chk("R9 trigger line 81", line_pend, 128'h1 << 81);
        wr(12'hE00, 32'd82);
        wr(12'hE00, 32'd255);
        chk("R9 out of range ignored", line_pend, 128'h1 << 81);
        wr(12'h188, 32'h0002_0000);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        wr(12'h400, 32'hFFFF_FFFF);
        wr(12'h001, 32'hFFFF_FFFF);
        wr(12'h3F0, 32'hFFFF_FFFF);
        chk("R10 enable untouched", line_en, '0);
        chk("R10 pending untouched", line_pend, '0);
        chk("R10 prio untouched", line_prio[15:0], 16'hFABC);
        rd(12'h400, d); chk("R10 read 0x400", d, 32'h0);
        rd(12'h3F0, d); chk("R10 read 0x3F0", d, 32'h0);
    endtask

    task automatic t_conflict;
        logic [31:0] d;
        @(negedge clk);
        irq_req[5] = 1'b1; ack_stb = 1'b1; ack_id = IW'(5);
        @(negedge clk);
        ack_stb = 1'b0;
        chk("R11 rise beats ack", line_pend, 128'h1 << 5);
        rd(12'h200, d); chk("R11 ack still activates", d, 32'h20);
        done(5);
        irq_req[5] = 1'b0;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h180; bus_wdata = 32'h20; irq_req[5] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R11 rise beats clear write", line_pend, 128'h1 << 5);
        rd(12'h100, d);
        wr(12'h000, 32'h1);
        chk("R12 rdata held", bus_rdata, 32'h20);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_enable;
        t_bounds;
        t_pending;
        t_request;
        t_ack;
        t_prio;
        t_trig;
        t_reserved;
        t_conflict;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule